// File: doc/BRIEF.md
# Audio Controller Control and Status Register Block

This block is the register file of a serial audio controller. It exposes word-aligned 32-bit registers at a 4-byte stride on a simple read/write bus. It turns command writes into the receiver, transmitter and clock enable levels. It keeps the receive holding word and a status word with sticky error flags. It also drives one level interrupt line from that status and a software-maintained interrupt mask.

The serial data path is not part of this block. It reports events through single-cycle strobes: a received word is ready, the receiver overran on a given time slot, the transmitter can take a word, and the transmitter underran on a given time slot. These strobes have no back-pressure; the data path must flag overruns itself. The outgoing word leaves through a one-cycle load strobe. Bus accesses complete in one cycle. Read data is combinational from the address while the read strobe is high. Register side effects take hold at the clock edge that ends the access.

Top module: `aud_ctl_regs`

## Requirements
- R1: A write to offset 0x00 controls three enable levels through bit pairs: bits 0/1 switch the receiver on/off, bits 2/3 switch the clock on/off, and bits 4/5 switch the transmitter on/off. When both bits of a pair are 1, the level goes off. When both are 0, the level holds. The new levels appear on the cycle after the write.
- R2: Writing bit 7 at offset 0x00 is a soft reset. It clears all three enables, every status bit and every mask bit, and the interrupt is low the cycle after. The mode register keeps its value.
- R3: The status word at 0x08 has this layout: bit 0 receiver on, bit 1 receive word pending, bit 2 receive overrun, bit 4 transmitter on, bit 5 transmit slot free, bit 6 transmit underrun. Bits 15:8 hold the per-slot overrun flags and bits 27:20 the per-slot underrun flags. All other bits read 0.
- R4: An overrun strobe sets bit 2 and bit 8+slot. An underrun strobe sets bit 6 and bit 20+slot. These bits stay set until they are cleared or a soft reset occurs.
- R5: Writing ones to 0x0C clears the matching sticky bits (2, 6, 15:8, 27:20). If a hardware set hits the same bit in that cycle, the set wins.
- R6: Writing ones to 0x10 sets the matching sticky bits. It has no effect on bits 0, 1, 4 or 5.
- R7: Writing ones to 0x14 sets mask bits and writing ones to 0x18 clears them. Only positions 1, 2, 5 and 6 exist. The mask reads back at 0x1C.
- R8: The interrupt is high exactly when some status bit at a mask position is set together with its mask bit.
- R9: A received-word strobe loads the holding word and sets bit 1. A read of 0x20 returns the word and clears bit 1. If a new word arrives in the same cycle as the read, the read returns the old word, bit 1 stays set, and the new word is held.
- R10: A write to 0x24 raises tx_load for exactly one cycle, starting the cycle after the write, with tx_word holding the written value. The write also clears bit 5. A transmit-free strobe sets bit 5, and it wins if both happen in the same cycle.
- R11: The mode register at 0x04 is read/write on all 32 bits. Offset 0x28 returns the VERSION parameter. The write-only offsets (0x00, 0x0C, 0x10, 0x14, 0x18, 0x24), unmapped offsets and unaligned addresses all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| ev_rx_word | input | 1 | Received word strobe |
| rx_word | input | 32 | Received word |
| ev_rx_ovr | input | 1 | Receive overrun strobe |
| rx_ovr_ch | input | CH_W | Slot that overran |
| ev_tx_ready | input | 1 | Transmitter can accept a word |
| ev_tx_udr | input | 1 | Transmit underrun strobe |
| tx_udr_ch | input | CH_W | Slot that underran |
| rx_enable | output | 1 | Receiver enable level |
| tx_enable | output | 1 | Transmitter enable level |
| clk_enable | output | 1 | Clock enable level |
| tx_load | output | 1 | One-cycle strobe for a new outgoing word |
| tx_word | output | 32 | Outgoing word |
| irq | output | 1 | Interrupt level |

## Verification
The bound checker checks these properties on every cycle:
- the off bit of the receiver pair overrides its on bit;
- a soft reset leaves enables, mask and interrupt cleared;
- overrun strobes always land in both the summary and the slot field;
- the overrun flag never drops without a clear write or a soft reset;
- a holding-word read without a new word drops the pending flag;
- an empty mask keeps the interrupt low.

Only the bench's scenarios can show the exact bit layout of the status word, the slot-to-bit mapping, and the full truth tables of the command pairs and the mask set/clear writes. The same applies to the ordering of a holding-word read against a word arriving in the same cycle, and to the read-back values of the mode, version and write-only offsets.

// File: rtl/aud_ctl_pkg.sv
package aud_ctl_pkg;
  localparam int unsigned OFF_CTRL  = 32'h00;
  localparam int unsigned OFF_MODE  = 32'h04;
  localparam int unsigned OFF_STAT  = 32'h08;
  localparam int unsigned OFF_SCLR  = 32'h0C;
  localparam int unsigned OFF_SSET  = 32'h10;
  localparam int unsigned OFF_IEN   = 32'h14;
  localparam int unsigned OFF_IDIS  = 32'h18;
  localparam int unsigned OFF_IMSK  = 32'h1C;
  localparam int unsigned OFF_RHOLD = 32'h20;
  localparam int unsigned OFF_THOLD = 32'h24;
  localparam int unsigned OFF_VER   = 32'h28;

  // status bit positions
  localparam int unsigned S_RXON  = 0;
  localparam int unsigned S_RXRDY = 1;
  localparam int unsigned S_RXOVR = 2;
  localparam int unsigned S_TXON  = 4;
  localparam int unsigned S_TXRDY = 5;
  localparam int unsigned S_TXUDR = 6;
  localparam int unsigned OVR_LSB = 8;
  localparam int unsigned UDR_LSB = 20;

  // command bit positions
  localparam int unsigned C_SWRST = 7;

  // implemented interrupt mask positions
  localparam logic [31:0] IRQ_BITS = 32'h0000_0066;
endpackage

// File: rtl/aud_cmd_pair.sv
module aud_cmd_pair #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         clr,
  input  logic [N-1:0] on_bits,
  input  logic [N-1:0] off_bits,
  output logic [N-1:0] lvl
);
  for (genvar g = 0; g < N; g++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lvl[g] <= 1'b0;
      else if (clr)              lvl[g] <= 1'b0;
      else if (wr && off_bits[g]) lvl[g] <= 1'b0;
      else if (wr && on_bits[g])  lvl[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_status_flags.sv
module aud_status_flags #(
  parameter int CH_N = 8,
  localparam int CH_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            swrst,
  input  logic            clr_wr,
  input  logic            set_wr,
  input  logic [31:0]     sw_bits,
  input  logic            ev_rx_word,
  input  logic            ev_rx_ovr,
  input  logic [CH_W-1:0] rx_ovr_ch,
  input  logic            ev_tx_ready,
  input  logic            ev_tx_udr,
  input  logic [CH_W-1:0] tx_udr_ch,
  input  logic            rhold_rd,
  input  logic            thold_wr,
  output logic [31:0]     flags
);
  import aud_ctl_pkg::*;

  localparam logic [31:0] CH_ONES = 32'((64'd1 << CH_N) - 64'd1);
  localparam logic [31:0] STICKY  = (32'd1 << S_RXOVR) | (32'd1 << S_TXUDR)
                                  | (CH_ONES << OVR_LSB) | (CH_ONES << UDR_LSB);

  logic [CH_N-1:0] ovr_hit, udr_hit;
  logic [31:0]     hw_set, sw_set, sw_clr, q;

  for (genvar g = 0; g < CH_N; g++) begin : g_slot
    assign ovr_hit[g] = ev_rx_ovr && (rx_ovr_ch == CH_W'(g));
    assign udr_hit[g] = ev_tx_udr && (tx_udr_ch == CH_W'(g));
  end

  always_comb begin
    hw_set                   = '0;
    hw_set[S_RXRDY]          = ev_rx_word;
    hw_set[S_RXOVR]          = ev_rx_ovr;
    hw_set[S_TXRDY]          = ev_tx_ready;
    hw_set[S_TXUDR]          = ev_tx_udr;
    hw_set[OVR_LSB +: CH_N]  = ovr_hit;
    hw_set[UDR_LSB +: CH_N]  = udr_hit;
    sw_set                   = set_wr ? (sw_bits & STICKY) : '0;
    sw_clr                   = clr_wr ? (sw_bits & STICKY) : '0;
    sw_clr[S_RXRDY]          = rhold_rd;
    sw_clr[S_TXRDY]          = thold_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (swrst) q <= '0;
    else            q <= (q & ~sw_clr) | sw_set | hw_set;
  end

  assign flags = q;
endmodule

// File: rtl/aud_irq_mask.sv
module aud_irq_mask (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        swrst,
  input  logic        en_wr,
  input  logic        dis_wr,
  input  logic [31:0] wbits,
  output logic [31:0] mask
);
  import aud_ctl_pkg::*;

  logic [31:0] q, set_v, clr_v;

  assign set_v = en_wr  ? (wbits & IRQ_BITS) : '0;
  assign clr_v = dis_wr ? (wbits & IRQ_BITS) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (swrst) q <= '0;
    else            q <= (q | set_v) & ~clr_v;
  end

  assign mask = q;
endmodule

// File: rtl/aud_ctl_regs.sv
module aud_ctl_regs #(
  parameter int          ADDR_W  = 8,
  parameter int          CH_N    = 8,
  parameter logic [31:0] VERSION = 32'h0001_0203,
  localparam int         CH_W    = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_rx_word,
  input  logic [31:0]       rx_word,
  input  logic              ev_rx_ovr,
  input  logic [CH_W-1:0]   rx_ovr_ch,
  input  logic              ev_tx_ready,
  input  logic              ev_tx_udr,
  input  logic [CH_W-1:0]   tx_udr_ch,
  output logic              rx_enable,
  output logic              tx_enable,
  output logic              clk_enable,
  output logic              tx_load,
  output logic [31:0]       tx_word,
  output logic              irq
);
  import aud_ctl_pkg::*;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  logic        w_ctrl, w_mode, w_sclr, w_sset, w_ien, w_idis, w_thold, r_rhold, swrst;
  logic [2:0]  lvl;
  logic [31:0] flags, stat_word, mask_word, mode_q, rx_hold;

  assign w_ctrl  = bus_wr && hit(bus_addr, OFF_CTRL);
  assign w_mode  = bus_wr && hit(bus_addr, OFF_MODE);
  assign w_sclr  = bus_wr && hit(bus_addr, OFF_SCLR);
  assign w_sset  = bus_wr && hit(bus_addr, OFF_SSET);
  assign w_ien   = bus_wr && hit(bus_addr, OFF_IEN);
  assign w_idis  = bus_wr && hit(bus_addr, OFF_IDIS);
  assign w_thold = bus_wr && hit(bus_addr, OFF_THOLD);
  assign r_rhold = bus_rd && hit(bus_addr, OFF_RHOLD);
  assign swrst   = w_ctrl && bus_wdata[C_SWRST];

  // level order: {tx, clk, rx}
  aud_cmd_pair #(.N(3)) u_pairs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (w_ctrl),
    .clr      (swrst),
    .on_bits  ({bus_wdata[4], bus_wdata[2], bus_wdata[0]}),
    .off_bits ({bus_wdata[5], bus_wdata[3], bus_wdata[1]}),
    .lvl      (lvl)
  );
  assign rx_enable  = lvl[0];
  assign clk_enable = lvl[1];
  assign tx_enable  = lvl[2];

  aud_status_flags #(.CH_N(CH_N)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .swrst      (swrst),
    .clr_wr     (w_sclr),
    .set_wr     (w_sset),
    .sw_bits    (bus_wdata),
    .ev_rx_word (ev_rx_word),
    .ev_rx_ovr  (ev_rx_ovr),
    .rx_ovr_ch  (rx_ovr_ch),
    .ev_tx_ready(ev_tx_ready),
    .ev_tx_udr  (ev_tx_udr),
    .tx_udr_ch  (tx_udr_ch),
    .rhold_rd   (r_rhold),
    .thold_wr   (w_thold),
    .flags      (flags)
  );

  aud_irq_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .swrst  (swrst),
    .en_wr  (w_ien),
    .dis_wr (w_idis),
    .wbits  (bus_wdata),
    .mask   (mask_word)
  );

  always_comb begin
    stat_word         = flags;
    stat_word[S_RXON] = rx_enable;
    stat_word[S_TXON] = tx_enable;
  end

  assign irq = |(stat_word & mask_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      rx_hold <= '0;
      tx_word <= '0;
      tx_load <= 1'b0;
    end else begin
      if (w_mode)     mode_q  <= bus_wdata;
      if (ev_rx_word) rx_hold <= rx_word;
      if (w_thold)    tx_word <= bus_wdata;
      tx_load <= w_thold;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit(bus_addr, OFF_MODE))  bus_rdata = mode_q;
      if (hit(bus_addr, OFF_STAT))  bus_rdata = stat_word;
      if (hit(bus_addr, OFF_IMSK))  bus_rdata = mask_word;
      if (hit(bus_addr, OFF_RHOLD)) bus_rdata = rx_hold;
      if (hit(bus_addr, OFF_VER))   bus_rdata = VERSION;
    end
  end
endmodule

// File: rtl/aud_ctl_chk.sv
module aud_ctl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              ev_rx_word,
  input logic              ev_rx_ovr,
  input logic              rx_enable,
  input logic              tx_enable,
  input logic              clk_enable,
  input logic              irq,
  input logic [31:0]       stat_word,
  input logic [31:0]       mask_word
);
  import aud_ctl_pkg::*;

  logic ctrl_w, soft_rst, sclr_bit2, rhold_rd;
  assign ctrl_w    = bus_wr && bus_addr == ADDR_W'(OFF_CTRL);
  assign soft_rst  = ctrl_w && bus_wdata[C_SWRST];
  assign sclr_bit2 = bus_wr && bus_addr == ADDR_W'(OFF_SCLR) && bus_wdata[S_RXOVR];
  assign rhold_rd  = bus_rd && bus_addr == ADDR_W'(OFF_RHOLD);

  // R1
  rx_off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_w && bus_wdata[1]) |=> !rx_enable);

  // R1
  rx_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_w && bus_wdata[0] && !bus_wdata[1] && !bus_wdata[C_SWRST]) |=> rx_enable);

  // R2
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!rx_enable && !tx_enable && !clk_enable && !irq && mask_word == '0));

  // R4
  ovr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_ovr && !soft_rst) |=> (stat_word[S_RXOVR] && $countones(stat_word[15:8]) != 0));

  // R4
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[S_RXOVR] && !sclr_bit2 && !soft_rst) |=> stat_word[S_RXOVR]);

  // R9
  rhold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rhold_rd && !ev_rx_word) |=> !stat_word[S_RXRDY]);

  // R8
  quiet_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_word == '0) |-> !irq);
endmodule

bind aud_ctl_regs aud_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .ev_rx_word (ev_rx_word),
  .ev_rx_ovr  (ev_rx_ovr),
  .rx_enable  (rx_enable),
  .tx_enable  (tx_enable),
  .clk_enable (clk_enable),
  .irq        (irq),
  .stat_word  (stat_word),
  .mask_word  (mask_word)
);

// File: tb/tb_aud_ctl_regs.sv
module tb_aud_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VER = 32'h0001_0203;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rx_word = '0, tx_word;
  logic        ev_rx_word = 0, ev_rx_ovr = 0, ev_tx_ready = 0, ev_tx_udr = 0;
  logic [2:0]  rx_ovr_ch = '0, tx_udr_ch = '0;
  logic        rx_enable, tx_enable, clk_enable, tx_load, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_ctl_regs #(.ADDR_W(8), .CH_N(8), .VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_rx_word(ev_rx_word), .rx_word(rx_word),
    .ev_rx_ovr(ev_rx_ovr), .rx_ovr_ch(rx_ovr_ch), .ev_tx_ready(ev_tx_ready), .ev_tx_udr(ev_tx_udr),
    .tx_udr_ch(tx_udr_ch), .rx_enable(rx_enable), .tx_enable(tx_enable), .clk_enable(clk_enable),
    .tx_load(tx_load), .tx_word(tx_word), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_rd = 1; bus_addr = a;
    #1 v = bus_rdata;
    step();
    bus_rd = 0;
  endtask

  function automatic logic [31:0] mpos(input logic [3:0] x);
    return (32'(x[0]) << 1) | (32'(x[1]) << 2) | (32'(x[2]) << 5) | (32'(x[3]) << 6);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [2:0]  lv;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R8: reset state
    rd(8'h08, v); chk("R3 reset status", v, 32'h0);
    rd(8'h1C, v); chk("R7 reset mask", v, 32'h0);
    chk("R8 reset irq", {31'b0, irq}, 32'h0);

    // R11 reads
    rd(8'h28, v); chk("R11 version", v, VER);
    wr(8'h04, 32'hDEAD_BEEF);
    rd(8'h04, v); chk("R11 mode readback", v, 32'hDEAD_BEEF);
    foreach (v[i]) begin end
    for (int a = 0; a < 64; a++) begin
      logic [7:0] ad = 8'(a);
      if (ad != 8'h04 && ad != 8'h08 && ad != 8'h1C && ad != 8'h20 && ad != 8'h28) begin
        rd(ad, v); chk("R11 write-only/unmapped read zero", v, 32'h0);
      end
    end

    // R1: sweep every command pair pattern
    lv = '0;
    for (int c = 0; c < 64; c++) begin
      logic [5:0] cb = 6'(c);
      wr(8'h00, {26'b0, cb});
      for (int p = 0; p < 3; p++) begin
        if (cb[2*p+1]) lv[p] = 1'b0;
        else if (cb[2*p]) lv[p] = 1'b1;
      end
      chk("R1 enable levels {tx,clk,rx}", {29'b0, tx_enable, clk_enable, rx_enable}, {29'b0, lv});
      rd(8'h08, v);
      chk("R3 status enable bits", v & 32'h11, {27'b0, lv[2], 3'b0, lv[0]});
    end

    // R2: soft reset clears enables, status, mask; mode kept
    wr(8'h00, 32'h15);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h00, 32'h80);
    chk("R2 enables after soft reset", {29'b0, tx_enable, clk_enable, rx_enable}, 32'h0);
    chk("R2 irq after soft reset", {31'b0, irq}, 32'h0);
    rd(8'h08, v); chk("R2 status after soft reset", v, 32'h0);
    rd(8'h1C, v); chk("R2 mask after soft reset", v, 32'h0);
    rd(8'h04, v); chk("R2 mode kept", v, 32'hDEAD_BEEF);

    // R6: set port only touches sticky bits
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R6 status-set all ones", v, 32'h0FF0_FF44);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R5 status-clear all ones", v, 32'h0);

    // R4 / R5: per-slot overrun and underrun
    for (int ch = 0; ch < 8; ch++) begin
      ev_rx_ovr = 1; rx_ovr_ch = 3'(ch); step(); ev_rx_ovr = 0;
      step();
      rd(8'h08, v); chk("R4 overrun slot", v, 32'h4 | (32'h1 << (8 + ch)));
      wr(8'h0C, 32'h4 | (32'h1 << (8 + ch)));
      rd(8'h08, v); chk("R5 overrun cleared", v, 32'h0);
      ev_tx_udr = 1; tx_udr_ch = 3'(ch); step(); ev_tx_udr = 0;
      rd(8'h08, v); chk("R4 underrun slot", v, 32'h40 | (32'h1 << (20 + ch)));
      wr(8'h0C, 32'h40 | (32'h1 << (20 + ch)));
      rd(8'h08, v); chk("R5 underrun cleared", v, 32'h0);
    end
    ev_rx_ovr = 1; rx_ovr_ch = 3'd1; step();
    rx_ovr_ch = 3'd6; step(); ev_rx_ovr = 0;
    rd(8'h08, v); chk("R4 overrun slots accumulate", v, 32'h4 | (32'h1 << 9) | (32'h1 << 14));
    wr(8'h0C, 32'h0000_0200);
    rd(8'h08, v); chk("R5 partial clear", v, 32'h4 | (32'h1 << 14));
    wr(8'h0C, 32'hFFFF_FFFF);

    // R5: set wins over same-cycle clear
    ev_tx_udr = 1; tx_udr_ch = 3'd5; step(); ev_tx_udr = 0;
    ev_rx_ovr = 1; rx_ovr_ch = 3'd3;
    bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'hFFFF_FFFF;
    step();
    bus_wr = 0; ev_rx_ovr = 0;
    rd(8'h08, v); chk("R5 hardware set beats clear", v, 32'h0000_0804);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R7: mask set/clear sweep
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        wr(8'h00, 32'h80);
        wr(8'h14, mpos(4'(p)));
        wr(8'h18, mpos(4'(q)));
        rd(8'h1C, v); chk("R7 mask after set then clear", v, mpos(4'(p) & ~4'(q)));
      end
    end
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R7 only implemented mask bits", v, 32'h66);

    // R8: irq over all mask patterns with all sources set
    wr(8'h00, 32'h80);
    ev_rx_word = 1; ev_tx_ready = 1; rx_word = 32'h1111_2222; step();
    ev_rx_word = 0; ev_tx_ready = 0;
    wr(8'h10, 32'h44);
    for (int p = 0; p < 16; p++) begin
      wr(8'h18, 32'hFF);
      wr(8'h14, mpos(4'(p)));
      chk("R8 irq vs mask", {31'b0, irq}, {31'b0, (p != 0)});
    end
    wr(8'h18, 32'hFF);
    wr(8'h14, 32'h4);
    chk("R8 irq with overrun masked in", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h4);
    chk("R8 irq drops after clear", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h15);
    wr(8'h14, 32'h66);
    rd(8'h08, v);
    chk("R8 enable bits do not raise irq", {31'b0, irq}, {31'b0, ((v & 32'h66) != 0)});

    // R9: receive holding word
    wr(8'h00, 32'h80);
    ev_rx_word = 1; rx_word = 32'hCAFE_0001; step(); ev_rx_word = 0;
    rd(8'h08, v); chk("R9 pending set", v & 32'h2, 32'h2);
    rd(8'h20, v); chk("R9 holding word", v, 32'hCAFE_0001);
    rd(8'h08, v); chk("R9 pending cleared by read", v & 32'h2, 32'h0);
    ev_rx_word = 1; rx_word = 32'hCAFE_0002; step(); ev_rx_word = 0;
    ev_rx_word = 1; rx_word = 32'hCAFE_0003;
    bus_rd = 1; bus_addr = 8'h20;
    #1 v = bus_rdata;
    step();
    bus_rd = 0; ev_rx_word = 0;
    chk("R9 same-cycle read returns old word", v, 32'hCAFE_0002);
    rd(8'h08, v); chk("R9 pending kept by new word", v & 32'h2, 32'h2);
    rd(8'h20, v); chk("R9 new word held", v, 32'hCAFE_0003);

    // R10: transmit holding
    ev_tx_ready = 1; step(); ev_tx_ready = 0;
    rd(8'h08, v); chk("R10 tx free set", v & 32'h20, 32'h20);
    chk("R10 tx_load idle", {31'b0, tx_load}, 32'h0);
    bus_wr = 1; bus_addr = 8'h24; bus_wdata = 32'h0BAD_F00D;
    step();
    bus_wr = 0;
    chk("R10 tx_load pulse", {31'b0, tx_load}, 32'h1);
    chk("R10 tx_word", tx_word, 32'h0BAD_F00D);
    step();
    chk("R10 tx_load one cycle", {31'b0, tx_load}, 32'h0);
    rd(8'h08, v); chk("R10 tx free cleared by write", v & 32'h20, 32'h0);
    ev_tx_ready = 1;
    bus_wr = 1; bus_addr = 8'h24; bus_wdata = 32'h1234_5678;
    step();
    bus_wr = 0; ev_tx_ready = 0;
    rd(8'h08, v); chk("R10 tx free set beats write", v & 32'h20, 32'h20);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule